// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of 32-bit registers to or from memory in one operation. A caller pulses `start` with a 16-bit selection mask, a start address, the address the last beat is expected to hit, the base register number and its value, and the current program counter. The sequencer walks the mask from bit 0 upward. It issues one word beat on a valid/ready memory port for each selected register and steps the address by 4 after each beat. Bits that are clear cost no beat.

Stores take their data from a 16-entry register file through a combinational read port. When the base register is among the stored registers, the value captured at `start` is stored in its place. Loads write registers 0 to 14 through a write port. A load of register 15 is treated as a program-counter load: the program counter receives the word with bit 0 cleared, and a one-bit instruction-set flag receives bit 0. When no program-counter load happens, the sequencer writes the captured program counter plus 4 as it finishes. A failed condition skips all memory traffic. The `done` pulse carries an address-mismatch error flag and an unsupported-mode error flag.

Top module: `blk_xfer_seq`

## Requirements
- R1: Mask bits are served in ascending order, with exactly one memory beat per set bit and no beat for a clear bit.
- R2: The first beat uses the start address, and each following beat uses the previous beat's address plus 4.
- R3: `done` is high for exactly one cycle per accepted operation. `err_addr` is high with it when the address of the last beat differs from `end_addr`. With no beats, the value compared against `end_addr` is start − 4.
- R4: On a store, the beat for the register whose number equals `base_idx` carries the `base_val` captured at `start`, not the register-file value.
- R5: On a load, each selected register 0..14 is written with the word returned by its own beat.
- R6: On a load with mask bit 15 set, `pc_we` pulses with `pc_wdata` equal to the word with bit 0 cleared, and `isa_flag` takes bit 0 of the word. `err_mode` is raised with `done` when that bit was 1.
- R7: With `cond_ok` low at `start`, no beat occurs, `done` pulses without errors, and the program counter is written as `pc_in` + 4.
- R8: While `mem_valid` is high and `mem_ready` is low, the address, direction and store data hold steady until the beat completes.
- R9: An all-zero mask produces no beat, one `done` pulse and a program-counter write of `pc_in` + 4.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `mem_valid`, `done`, `pc_we` and `isa_flag` are all low.
- R12: An operation that does not load register 15 ends with a single program-counter write of `pc_in` + 4, in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| cond_ok | input | 1 | Condition passed; 0 skips all memory traffic |
| mask | input | 16 | Register selection, bit n = register n |
| start_addr | input | 32 | Address of the first beat |
| end_addr | input | 32 | Expected address of the last beat |
| base_idx | input | 4 | Base register number |
| base_val | input | 32 | Base register value before the operation |
| pc_in | input | 32 | Current program counter |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_addr | output | 1 | Last beat address mismatched `end_addr` (valid with `done`) |
| err_mode | output | 1 | Loaded program counter selected the unsupported instruction set (valid with `done`) |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_write | output | 1 | 1 = store beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid when `mem_valid` and `mem_ready` |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| pc_we | output | 1 | Program-counter write enable |
| pc_wdata | output | 32 | Program-counter write value |
| isa_flag | output | 1 | Instruction-set state flag |

## Verification
The bench builds the block with its defaults: 32-bit data and addresses, 16 registers and a step of 4. At these values register 15 is the program counter, so the program-counter load and the base-register substitution are both reachable in one short mask. A ready signal from a pseudo-random generator stretches beats by one or more cycles. This exposes the hold behaviour and lets a second `start` arrive mid-operation. A deliberately wrong end address and odd and even program-counter words cover both error flags.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_load,
  input  logic              cond_ok,
  input  logic [NREG-1:0]   mask,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [$clog2(NREG)-1:0] base_idx,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] pc_in,
  output logic              busy,
  output logic              done,
  output logic              err_addr,
  output logic              err_mode,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [$clog2(NREG)-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [$clog2(NREG)-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_wdata,
  output logic              isa_flag
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t            st;
  logic [NREG-1:0]   rem;
  logic [ADDR_W-1:0] addr_q, last_q, end_q;
  logic [IDX_W-1:0]  base_q;
  logic [DATA_W-1:0] bval_q, pcn_q;
  logic              load_q, skip_q, pcld_q, isa_q;
  logic [IDX_W-1:0]  idx;
  logic              pend, beat, fin, pc_beat;

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) idx = IDX_W'(i);
  end

  assign pend    = (st == S_RUN) && (rem != '0);
  assign beat    = pend && mem_ready;
  assign fin     = (st == S_FIN);
  assign pc_beat = beat && load_q && (idx == PC_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      addr_q <= '0;
      last_q <= '0;
      end_q  <= '0;
      base_q <= '0;
      bval_q <= '0;
      pcn_q  <= '0;
      load_q <= 1'b0;
      skip_q <= 1'b0;
      pcld_q <= 1'b0;
      isa_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= cond_ok ? S_RUN : S_FIN;
          rem    <= cond_ok ? mask : '0;
          addr_q <= start_addr;
          last_q <= start_addr - ADDR_W'(STEP);
          end_q  <= end_addr;
          base_q <= base_idx;
          bval_q <= base_val;
          pcn_q  <= pc_in + DATA_W'(STEP);
          load_q <= is_load;
          skip_q <= !cond_ok;
          pcld_q <= 1'b0;
        end
        S_RUN: begin
          if (rem == '0) st <= S_FIN;
          else if (mem_ready) begin
            rem[idx] <= 1'b0;
            last_q   <= addr_q;
            addr_q   <= addr_q + ADDR_W'(STEP);
            if (pc_beat) begin
              pcld_q <= 1'b1;
              isa_q  <= mem_rdata[0];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = fin;
  assign err_addr  = fin && !skip_q && (last_q != end_q);
  assign err_mode  = fin && pcld_q && isa_q;
  assign mem_valid = pend;
  assign mem_write = !load_q;
  assign mem_addr  = addr_q;
  assign rf_raddr  = idx;
  assign mem_wdata = (idx == base_q) ? bval_q : rf_rdata;
  assign rf_we     = beat && load_q && (idx != PC_IDX);
  assign rf_waddr  = idx;
  assign rf_wdata  = mem_rdata;
  assign pc_we     = pc_beat || (fin && !pcld_q);
  assign pc_wdata  = fin ? pcn_q : {mem_rdata[DATA_W-1:1], 1'b0};
  assign isa_flag  = isa_q;

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));
  a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_addr || err_mode) |-> done);
  a_r5_rf_write_on_load_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_valid && mem_ready && !mem_write);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  a_r12_pc_single: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we && !mem_valid |-> done);
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, is_load = 0, cond_ok = 1;
  logic [15:0] mask = 0;
  logic [31:0] start_addr = 0, end_addr = 0, base_val = 0, pc_in = 32'h1000;
  logic [3:0] base_idx = 0;
  logic busy, done, err_addr, err_mode, mem_valid, mem_write, rf_we, pc_we, isa_flag;
  logic mem_ready = 1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, pc_wdata;
  logic [3:0] rf_raddr, rf_waddr;

  logic [31:0] mem_m [64];
  logic [31:0] rf_m [16];
  assign mem_rdata = mem_m[mem_addr[7:2]];
  assign rf_rdata  = rf_m[rf_raddr];

  blk_xfer_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .cond_ok(cond_ok),
    .mask(mask), .start_addr(start_addr), .end_addr(end_addr), .base_idx(base_idx), .base_val(base_val),
    .pc_in(pc_in), .busy(busy), .done(done), .err_addr(err_addr), .err_mode(err_mode),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .isa_flag(isa_flag));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int beats, pcw, dones;
  logic [31:0] baddr [16];
  logic [31:0] pc_seen;
  logic stall = 0;
  logic [7:0] lfsr = 8'h5a;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready) begin
      if (beats < 16) baddr[beats] <= mem_addr;
      beats <= beats + 1;
      if (mem_write) mem_m[mem_addr[7:2]] <= mem_wdata;
    end
    if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    if (pc_we) begin pc_seen <= pc_wdata; pcw <= pcw + 1; end
    if (done) dones <= dones + 1;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall ? lfsr[0] : 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic d_err_a, d_err_m;

  task automatic run(logic ld, logic c, logic [15:0] m, logic [31:0] sa, logic [31:0] ea,
                     logic [3:0] bi, logic [31:0] bv);
    @(negedge clk);
    beats = 0; pcw = 0; dones = 0;
    is_load = ld; cond_ok = c; mask = m; start_addr = sa; end_addr = ea;
    base_idx = bi; base_val = bv; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    d_err_a = err_addr; d_err_m = err_mode;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 busy", {31'b0, busy}, 0);
    check("R11 mem_valid", {31'b0, mem_valid}, 0);
    check("R11 done", {31'b0, done}, 0);
    check("R11 pc_we", {31'b0, pc_we}, 0);
    check("R11 isa_flag", {31'b0, isa_flag}, 0);
  endtask

  task automatic t_store_sparse;
    for (int i = 0; i < 16; i++) rf_m[i] = 32'hA000_0000 + i;
    run(0, 1, 16'h8421, 32'h40, 32'h4C, 4'd3, 32'hDEAD);
    check("R1 beat count", beats, 4);
    check("R2 addr0", baddr[0], 32'h40);
    check("R2 addr3", baddr[3], 32'h4C);
    check("R1 order reg0", mem_m[16], 32'hA000_0000);
    check("R1 order reg5", mem_m[17], 32'hA000_0005);
    check("R1 order reg10", mem_m[18], 32'hA000_000A);
    check("R1 order reg15", mem_m[19], 32'hA000_000F);
    check("R3 no err", {31'b0, d_err_a}, 0);
    check("R3 one done", dones, 1);
    check("R12 pc", pc_seen, 32'h1004);
    check("R12 pc writes", pcw, 1);
  endtask

  task automatic t_store_base;
    stall = 1;
    for (int i = 0; i < 16; i++) rf_m[i] = 32'hB000_0000 + i;
    run(0, 1, 16'h00F0, 32'h80, 32'h8C, 4'd5, 32'hBEEF_0000);
    check("R4 reg4", mem_m[32], 32'hB000_0004);
    check("R4 base value", mem_m[33], 32'hBEEF_0000);
    check("R8 reg7 under stall", mem_m[35], 32'hB000_0007);
    check("R8 beats under stall", beats, 4);
    stall = 0;
  endtask

  task automatic t_load;
    mem_m[0] = 32'h1111_0000; mem_m[1] = 32'h2222_0001; mem_m[2] = 32'h3333_000E;
    for (int i = 0; i < 16; i++) rf_m[i] = 0;
    run(1, 1, 16'h4003, 32'h0, 32'h8, 4'd9, 0);
    check("R5 reg0", rf_m[0], 32'h1111_0000);
    check("R5 reg1", rf_m[1], 32'h2222_0001);
    check("R5 reg14", rf_m[14], 32'h3333_000E);
    check("R5 reg2 untouched", rf_m[2], 0);
    check("R12 load pc", pc_seen, 32'h1004);
  endtask

  task automatic t_load_pc_even;
    mem_m[4] = 32'h7; mem_m[5] = 32'h0000_1234;
    run(1, 1, 16'h8001, 32'h10, 32'h14, 4'd9, 0);
    check("R6 pc even", pc_seen, 32'h1234);
    check("R6 pc writes", pcw, 1);
    check("R6 flag 0", {31'b0, isa_flag}, 0);
    check("R6 no mode err", {31'b0, d_err_m}, 0);
    check("R5 reg0 before pc", rf_m[0], 32'h7);
  endtask

  task automatic t_load_pc_odd;
    mem_m[6] = 32'h0000_2001;
    run(1, 1, 16'h8000, 32'h18, 32'h18, 4'd9, 0);
    check("R6 pc odd cleared", pc_seen, 32'h2000);
    check("R6 flag 1", {31'b0, isa_flag}, 1);
    check("R6 mode err", {31'b0, d_err_m}, 1);
  endtask

  task automatic t_bad_end;
    run(0, 1, 16'h0003, 32'h40, 32'h48, 4'd9, 0);
    check("R3 mismatch err", {31'b0, d_err_a}, 1);
    check("R3 beats", beats, 2);
  endtask

  task automatic t_cond_fail;
    run(1, 0, 16'hFFFF, 32'h40, 32'h0, 4'd0, 0);
    check("R7 no beats", beats, 0);
    check("R7 pc", pc_seen, 32'h1004);
    check("R7 no err", {30'b0, d_err_a, d_err_m}, 0);
  endtask

  task automatic t_empty;
    run(0, 1, 16'h0000, 32'h40, 32'h3C, 4'd0, 0);
    check("R9 no beats", beats, 0);
    check("R9 one done", dones, 1);
    check("R9 pc", pc_seen, 32'h1004);
    check("R9 no err", {31'b0, d_err_a}, 0);
  endtask

  task automatic t_busy_start;
    stall = 1;
    @(negedge clk);
    beats = 0; dones = 0;
    is_load = 0; cond_ok = 1; mask = 16'h000F; start_addr = 32'h40; end_addr = 32'h4C;
    base_idx = 4'd9; start = 1;
    @(negedge clk);
    mask = 16'hFF00; start_addr = 32'h80; end_addr = 32'hC0;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    d_err_a = err_addr;
    repeat (4) @(negedge clk);
    check("R10 beats of first op", beats, 4);
    check("R10 single done", dones, 1);
    check("R10 first op addr ok", {31'b0, d_err_a}, 0);
    stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 0;
    for (int i = 0; i < 16; i++) rf_m[i] = 0;
    beats = 0; pcw = 0; dones = 0; pc_seen = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_store_sparse;
    t_store_base;
    t_load;
    t_load_pc_even;
    t_load_pc_odd;
    t_bad_end;
    t_cond_fail;
    t_empty;
    t_busy_start;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule